// File: doc/BRIEF.md
# LIN Response Byte-Length Counter

This block keeps track of how many data bytes a LIN response carries and how far the response has progressed. Software first loads two 4-bit length fields, one for transmit and one for receive. It then issues a response command that names the direction. The field for the active direction holds the number of data bytes. The other field is reused as a live counter of bytes that completed without error.

The serial engine reports every byte that finished cleanly with a one-cycle strobe. Before each byte, the block says whether that byte is data or the checksum. After the checksum completes, it pulses a done output. If the engine reports an error, the response stops and the counter keeps its value, so software can read how many bytes got through and resume from there. A new command at any time discards the response in progress and starts over.

Top module: `lin_resp_len`

## Requirements
- R1: After reset both length fields read 0, and respActive, nextIsChecksum and respDone are all 0.
- R2: While no response is active, a write strobe loads both fields on the next clock edge. While a response is active, the write is ignored and neither field changes.
- R3: On a command, the length field for the selected direction (txLen when cmdIsTx=1, rxLen when cmdIsTx=0) is clamped: any stored value above 8 reads back as 8 on the next cycle.
- R4: On a command, the field of the opposite direction (rxLen for transmit, txLen for receive) is cleared to 0 and becomes the progress counter.
- R5: While a response is active, nextIsChecksum is 1 exactly when the counter equals the clamped length; at all other times it is 0.
- R6: A byte strobe on a data byte raises the counter by one on the next cycle.
- R7: A transmit response with length 0 flags its very first byte as the checksum.
- R8: A receive response with length 0 treats its very first byte as the checksum.
- R9: A byte strobe on the checksum byte ends the response and makes respDone high for exactly one cycle. The counter stays equal to the length.
- R10: An error while a response is active ends the response without respDone. The counter keeps its value, and later byte strobes leave it unchanged.
- R11: A command issued during an active response aborts it and restarts with the counter at 0.
- R12: A command takes priority over a byte strobe or an error in the same cycle: the new response starts with its counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenWrEn | input | 1 | Write strobe for the two length fields |
| wrTxLen | input | 4 | Transmit length value to write |
| wrRxLen | input | 4 | Receive length value to write |
| cmdValid | input | 1 | Response command strobe |
| cmdIsTx | input | 1 | Command direction: 1 transmit, 0 receive |
| byteDone | input | 1 | A byte was sent or received successfully |
| errIn | input | 1 | The serial engine detected an error |
| txLenField | output | 4 | Transmit length, or the progress counter during receive |
| rxLenField | output | 4 | Receive length, or the progress counter during transmit |
| nextIsChecksum | output | 1 | The pending byte is the checksum |
| respDone | output | 1 | One-cycle pulse after the checksum completes |
| respActive | output | 1 | A response is in progress |

## Verification
The bench drives zero lengths in both directions: a design that misplaces the checksum would expect a data byte first and run one byte too long. It writes lengths of 12 and 15, and a design without the clamp would count past 8. Errors are injected on the first data byte, on a middle byte and on the checksum byte. A design that keeps counting after an error, or raises respDone anyway, would corrupt the recovery point. Finally, a command lands in the same cycle as a byte strobe or an error, and during a response in progress, where a wrong priority would leave a stale count or a dead response.

// File: rtl/lin_len_pkg.sv
package lin_len_pkg;

  typedef struct packed {
    logic wrFields;   // load both fields from the write port
    logic startResp;  // clamp the length and clear the counter
    logic dirTx;      // direction for the current or starting response
    logic countUp;    // advance the progress counter
    logic active;     // response in progress
  } lenCtrl_t;

endpackage

// File: rtl/lin_len_ctrl.sv
module lin_len_ctrl
  import lin_len_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lenWrEn,
  input  logic     cmdValid,
  input  logic     cmdIsTx,
  input  logic     byteDone,
  input  logic     errIn,
  input  logic     atChecksum,
  output lenCtrl_t ctrl,
  output logic     respDone,
  output logic     respActive
);

  logic activeQ;
  logic dirTxQ;
  logic doneQ;
  logic checksumHit;

  assign checksumHit = activeQ && byteDone && atChecksum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      dirTxQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmdValid) begin
        activeQ <= 1'b1;
        dirTxQ  <= cmdIsTx;
      end else if (activeQ && errIn) begin
        activeQ <= 1'b0;
      end else if (checksumHit) begin
        activeQ <= 1'b0;
        doneQ   <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.wrFields  = lenWrEn && !activeQ && !cmdValid;
    ctrl.startResp = cmdValid;
    ctrl.dirTx     = cmdValid ? cmdIsTx : dirTxQ;
    ctrl.countUp   = activeQ && !cmdValid && !errIn && byteDone && !atChecksum;
    ctrl.active    = activeQ;
  end

  assign respDone   = doneQ;
  assign respActive = activeQ;

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && byteDone && atChecksum && !errIn && !cmdValid) |=> (respDone && !respActive));

  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && errIn && !cmdValid) |=> (!respActive && !respDone));

  p_cmd_starts_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (respActive && !respDone));

endmodule

// File: rtl/lin_len_datapath.sv
module lin_len_datapath
  import lin_len_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int MAX_DATA = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lenCtrl_t         ctrl,
  input  logic [LEN_W-1:0] wrTxLen,
  input  logic [LEN_W-1:0] wrRxLen,
  output logic [LEN_W-1:0] txLenField,
  output logic [LEN_W-1:0] rxLenField,
  output logic             atChecksum,
  output logic             nextIsChecksum
);

  localparam int FIELD_MAX = (1 << LEN_W) - 1;
  localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_DATA);
  localparam logic [LEN_W-1:0] ONE_V = LEN_W'(1);

  logic [LEN_W-1:0] txQ;
  logic [LEN_W-1:0] rxQ;
  logic [LEN_W-1:0] txClamp;
  logic [LEN_W-1:0] rxClamp;
  logic [LEN_W-1:0] lenSel;
  logic [LEN_W-1:0] cntSel;

  generate
    if (MAX_DATA >= FIELD_MAX) begin : g_noClamp
      assign txClamp = txQ;
      assign rxClamp = rxQ;
    end else begin : g_clamp
      assign txClamp = (txQ > MAX_V) ? MAX_V : txQ;
      assign rxClamp = (rxQ > MAX_V) ? MAX_V : rxQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ <= '0;
      rxQ <= '0;
    end else if (ctrl.wrFields) begin
      txQ <= wrTxLen;
      rxQ <= wrRxLen;
    end else if (ctrl.startResp) begin
      if (ctrl.dirTx) begin
        txQ <= txClamp;
        rxQ <= '0;
      end else begin
        rxQ <= rxClamp;
        txQ <= '0;
      end
    end else if (ctrl.countUp) begin
      if (ctrl.dirTx) rxQ <= rxQ + ONE_V;
      else            txQ <= txQ + ONE_V;
    end
  end

  assign lenSel         = ctrl.dirTx ? txQ : rxQ;
  assign cntSel         = ctrl.dirTx ? rxQ : txQ;
  assign atChecksum     = (cntSel == lenSel);
  assign nextIsChecksum = ctrl.active && atChecksum;
  assign txLenField     = txQ;
  assign rxLenField     = rxQ;

  p_len_clamped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.startResp) |-> (lenSel <= MAX_V));

  p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.startResp && ctrl.dirTx) |=> (rxQ == '0));

  p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.startResp && !ctrl.dirTx) |=> (txQ == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.startResp) |-> (cntSel <= lenSel));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.active && !ctrl.wrFields && !ctrl.startResp) |=> ($stable(txQ) && $stable(rxQ)));

endmodule

// File: rtl/lin_resp_len.sv
module lin_resp_len
  import lin_len_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lenWrEn,
  input  logic [3:0] wrTxLen,
  input  logic [3:0] wrRxLen,
  input  logic       cmdValid,
  input  logic       cmdIsTx,
  input  logic       byteDone,
  input  logic       errIn,
  output logic [3:0] txLenField,
  output logic [3:0] rxLenField,
  output logic       nextIsChecksum,
  output logic       respDone,
  output logic       respActive
);

  lenCtrl_t ctrl;
  logic     atChecksum;

  lin_len_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lenWrEn    (lenWrEn),
    .cmdValid   (cmdValid),
    .cmdIsTx    (cmdIsTx),
    .byteDone   (byteDone),
    .errIn      (errIn),
    .atChecksum (atChecksum),
    .ctrl       (ctrl),
    .respDone   (respDone),
    .respActive (respActive)
  );

  lin_len_datapath #(.LEN_W(4), .MAX_DATA(8)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .wrTxLen        (wrTxLen),
    .wrRxLen        (wrRxLen),
    .txLenField     (txLenField),
    .rxLenField     (rxLenField),
    .atChecksum     (atChecksum),
    .nextIsChecksum (nextIsChecksum)
  );

  p_checksum_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    nextIsChecksum |-> respActive);

endmodule

// File: tb/tb_lin_resp_len.sv
module tb_lin_resp_len;

  logic       clk = 1'b0;
  logic       rstN;
  logic       lenWrEn, cmdValid, cmdIsTx, byteDone, errIn;
  logic [3:0] wrTxLen, wrRxLen;
  logic [3:0] txLenField, rxLenField;
  logic       nextIsChecksum, respDone, respActive;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  lin_resp_len dut (
    .clk(clk), .rstN(rstN), .lenWrEn(lenWrEn), .wrTxLen(wrTxLen), .wrRxLen(wrRxLen),
    .cmdValid(cmdValid), .cmdIsTx(cmdIsTx), .byteDone(byteDone), .errIn(errIn),
    .txLenField(txLenField), .rxLenField(rxLenField), .nextIsChecksum(nextIsChecksum),
    .respDone(respDone), .respActive(respActive)
  );

  // {isTx, lenWritten, expLen, errAt (15 = no error)}
  localparam logic [12:0] VEC [9] = '{
    {1'b1, 4'd3,  4'd3, 4'd15},
    {1'b0, 4'd5,  4'd5, 4'd15},
    {1'b1, 4'd0,  4'd0, 4'd15},
    {1'b0, 4'd0,  4'd0, 4'd15},
    {1'b1, 4'd12, 4'd8, 4'd15},
    {1'b0, 4'd15, 4'd8, 4'd15},
    {1'b1, 4'd6,  4'd6, 4'd2},
    {1'b0, 4'd8,  4'd8, 4'd0},
    {1'b0, 4'd4,  4'd4, 4'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic writeLen(input logic [3:0] tx, input logic [3:0] rx);
    lenWrEn = 1'b1; wrTxLen = tx; wrRxLen = rx;
    @(negedge clk);
    lenWrEn = 1'b0;
  endtask

  task automatic issueCmd(input logic isTx);
    cmdValid = 1'b1; cmdIsTx = isTx;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseByte();
    byteDone = 1'b1;
    @(negedge clk);
    byteDone = 1'b0;
  endtask

  task automatic pulseErr();
    errIn = 1'b1;
    @(negedge clk);
    errIn = 1'b0;
  endtask

  function automatic int cntOf(input logic isTx);
    return isTx ? int'(rxLenField) : int'(txLenField);
  endfunction

  function automatic int lenOf(input logic isTx);
    return isTx ? int'(txLenField) : int'(rxLenField);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; lenWrEn = 1'b0; wrTxLen = '0; wrRxLen = '0;
    cmdValid = 1'b0; cmdIsTx = 1'b0; byteDone = 1'b0; errIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txLen", txLenField, 0);
    chk("R1 rxLen", rxLenField, 0);
    chk("R1 active", respActive, 0);
    chk("R1 checksum", nextIsChecksum, 0);
    chk("R1 done", respDone, 0);

    for (int v = 0; v < 9; v++) begin
      logic       isTx;
      int         lenW, expLen, errAt;
      logic       stopped;
      isTx   = VEC[v][12];
      lenW   = int'(VEC[v][11:8]);
      expLen = int'(VEC[v][7:4]);
      errAt  = int'(VEC[v][3:0]);
      stopped = 1'b0;

      if (isTx) writeLen(VEC[v][11:8], 4'hA);
      else      writeLen(4'h7, VEC[v][11:8]);
      chk("R2 write len", lenOf(isTx), lenW);
      chk("R2 write other", cntOf(isTx), isTx ? 10 : 7);

      issueCmd(isTx);
      chk("R3 clamped len", lenOf(isTx), expLen);
      chk("R4 counter cleared", cntOf(isTx), 0);
      chk("R11 active", respActive, 1);

      for (int i = 0; i <= expLen; i++) begin
        if (!stopped) begin
          if (expLen == 0) chk(isTx ? "R7 zero-len checksum" : "R8 zero-len checksum", nextIsChecksum, 1);
          else             chk("R5 checksum flag", nextIsChecksum, (i == expLen) ? 1 : 0);
          if (errAt == i) begin
            pulseErr();
            chk("R10 count frozen", cntOf(isTx), i);
            chk("R10 stopped", respActive, 0);
            chk("R10 no done", respDone, 0);
            pulseByte();
            chk("R10 ignore byte", cntOf(isTx), i);
            chk("R10 still no done", respDone, 0);
            stopped = 1'b1;
          end else begin
            pulseByte();
            if (i < expLen) begin
              chk("R6 count", cntOf(isTx), i + 1);
            end else begin
              chk("R9 done pulse", respDone, 1);
              chk("R9 inactive", respActive, 0);
              chk("R9 count kept", cntOf(isTx), expLen);
              @(negedge clk);
              chk("R9 done single", respDone, 0);
              chk("R5 idle flag", nextIsChecksum, 0);
            end
          end
        end
      end
    end

    // R2: write ignored during an active response
    writeLen(4'd5, 4'd3);
    issueCmd(1'b1);
    writeLen(4'd2, 4'd9);
    chk("R2 ignored tx", txLenField, 5);
    chk("R2 ignored rx", rxLenField, 0);

    // R11: abort a response in progress
    pulseByte();
    pulseByte();
    chk("R6 mid count", rxLenField, 2);
    issueCmd(1'b1);
    chk("R11 restart count", rxLenField, 0);
    chk("R11 restart len", txLenField, 5);
    chk("R11 still active", respActive, 1);

    // R12: command wins over a byte strobe in the same cycle
    pulseByte();
    chk("R6 count one", rxLenField, 1);
    cmdValid = 1'b1; cmdIsTx = 1'b1; byteDone = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; byteDone = 1'b0;
    chk("R12 cmd over byte", rxLenField, 0);

    // R12: command wins over an error in the same cycle
    cmdValid = 1'b1; cmdIsTx = 1'b1; errIn = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; errIn = 1'b0;
    chk("R12 cmd over err", respActive, 1);
    chk("R12 count zero", rxLenField, 0);

    // Run the restarted response to completion
    for (int i = 0; i < 5; i++) pulseByte();
    chk("R5 at checksum", nextIsChecksum, 1);
    pulseByte();
    chk("R9 final done", respDone, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule